// File: doc/BRIEF.md
# Bridge Configuration Cycle Router

This block decides what a PCI-to-PCI style bridge does with a type 1 configuration request arriving from its upstream side. It keeps three bus numbers (the upstream bus the bridge sits on, the bus directly below it, and the highest-numbered bus reachable through it) and compares each request's target bus against them. The result is one of four routes: convert to a type 0 cycle on the bus directly below, forward unchanged as type 1 further downstream, reject, or leave unclaimed so another decoder may take it.

The three bus numbers share one 24-bit register with a byte-enabled write port and a read port that always shows the current contents. Requests enter through a valid/ready handshake. The route is registered one clock after acceptance and is held on a valid/ready response channel until it is taken. While a response is pending, no new request is accepted. The route uses the bus numbers as they stood when the request was accepted, so register writes that overlap a request do not affect its route.

The control is a two-state machine. **ST_IDLE** raises `req_ready`. Transition **T_ACCEPT** (`req_valid` in ST_IDLE) captures the route and moves to **ST_RESP**. **ST_RESP** raises `rsp_valid`. Transition **T_RELEASE** (`rsp_ready` in ST_RESP) returns to ST_IDLE. Otherwise each state holds.

Top module: `cfg_route_top`

## Requirements
- R1: After reset, `reg_rdata` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A write with `reg_wr` high updates byte lane k (k = 0 upstream bus, bits 7:0; k = 1 bus below, bits 15:8; k = 2 highest bus, bits 23:16) only when `reg_be[k]` is 1. Lanes whose enable is 0 keep their value.
- R3: `reg_rdata` shows the written value from the clock edge that performs the write.
- R4: A target bus equal to the bus-below number gives route code 1 (convert to type 0). This check has the highest priority.
- R5: Otherwise, a target greater than the bus-below number and no greater than the highest bus gives route code 2 (forward as type 1).
- R6: Otherwise, a target equal to the upstream bus number gives route code 3 (reject).
- R7: Any other target, including one below the upstream bus number, one above the highest bus, or one between upstream and bus-below, gives route code 0 (not claimed).
- R8: `req_ready` is high only when no response is pending. A request accepted at a clock edge raises `rsp_valid` at that same edge.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_route` hold steady. After an edge with both high, `rsp_valid` is low.
- R10: A register write in the same cycle as acceptance, or while the response is pending, does not change that request's route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 3 | Byte enables, one per bus number |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Current register contents |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_bus | input | 8 | Target bus number of the request |
| rsp_valid | output | 1 | Route available |
| rsp_ready | input | 1 | Route taken when high with rsp_valid |
| rsp_route | output | 2 | Route code: 0 unclaimed, 1 type 0, 2 type 1, 3 reject |

## Verification
A register update and a request acceptance can fall in the same clock. In that case the new bus numbers must take effect while the in-flight route keeps the old ones. The bench provokes this by asserting `reg_wr` with `req_valid` in one cycle, and again while a response is held pending by a low `rsp_ready`. Each time it compares the delivered route against a model evaluated on the bus numbers from before the write, and it checks the readback against the new values.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
    localparam int ROUTE_W = 2;

    typedef enum logic [ROUTE_W-1:0] {
        RT_UNCLAIMED = 2'd0,
        RT_TYPE0     = 2'd1,
        RT_TYPE1     = 2'd2,
        RT_REJECT    = 2'd3
    } route_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fsm_e;
endpackage

// File: rtl/cfg_route_regs.sv
module cfg_route_regs #(
    parameter int BUS_W   = 8,
    parameter int FIELD_N = 3,
    localparam int REG_W  = BUS_W * FIELD_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [FIELD_N-1:0] be,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata
);
    genvar k;
    generate
        for (k = 0; k < FIELD_N; k++) begin : g_lane
            logic [BUS_W-1:0] lane_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lane_q <= '0;
                else if (wr && be[k])
                    lane_q <= wdata[k*BUS_W +: BUS_W];
            end
            assign rdata[k*BUS_W +: BUS_W] = lane_q;
        end
    endgenerate
endmodule

// File: rtl/cfg_route_cmp.sv
module cfg_route_cmp
    import cfg_route_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] target,
    input  logic [BUS_W-1:0] up_bus,
    input  logic [BUS_W-1:0] below_bus,
    input  logic [BUS_W-1:0] top_bus,
    output route_e           route
);
    logic hit_below, hit_range, hit_up;

    assign hit_below = (target == below_bus);
    assign hit_range = (target > below_bus) && (target <= top_bus);
    assign hit_up    = (target == up_bus);

    always_comb begin
        if (hit_below)
            route = RT_TYPE0;
        else if (hit_range)
            route = RT_TYPE1;
        else if (hit_up)
            route = RT_REJECT;
        else
            route = RT_UNCLAIMED;
    end
endmodule

// File: rtl/cfg_route_fsm.sv
module cfg_route_fsm
    import cfg_route_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   rsp_ready,
    input  route_e route_in,
    output logic   req_ready,
    output logic   rsp_valid,
    output route_e route_q
);
    fsm_e state_q, state_d;
    logic take;

    assign take = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            route_q <= RT_UNCLAIMED;
        end else begin
            state_q <= state_d;
            if (take)
                route_q <= route_in;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
    import cfg_route_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int FIELD_N = 3,
    localparam int REG_W  = BUS_W * FIELD_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [FIELD_N-1:0] reg_be,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [BUS_W-1:0]   req_bus,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [ROUTE_W-1:0] rsp_route
);
    route_e route_c, route_r;

    cfg_route_regs #(.BUS_W(BUS_W), .FIELD_N(FIELD_N)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .be    (reg_be),
        .wdata (reg_wdata),
        .rdata (reg_rdata)
    );

    cfg_route_cmp #(.BUS_W(BUS_W)) u_cmp (
        .target    (req_bus),
        .up_bus    (reg_rdata[0*BUS_W +: BUS_W]),
        .below_bus (reg_rdata[1*BUS_W +: BUS_W]),
        .top_bus   (reg_rdata[2*BUS_W +: BUS_W]),
        .route     (route_c)
    );

    cfg_route_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .rsp_ready (rsp_ready),
        .route_in  (route_c),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .route_q   (route_r)
    );

    assign rsp_route = route_r;
endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk #(
    parameter int BUS_W   = 8,
    parameter int FIELD_N = 3,
    localparam int REG_W  = BUS_W * FIELD_N
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [FIELD_N-1:0] reg_be,
    input logic [REG_W-1:0]   reg_rdata,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [1:0]         rsp_route
);
    AST_READY_XOR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid)); // R8
    AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R8
    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_route))); // R9
    AST_RSP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> !rsp_valid); // R9
    AST_LANE0_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_be[0]) |=> $stable(reg_rdata[BUS_W-1:0])); // R2
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(reg_rdata)); // R2
endmodule

bind cfg_route_top cfg_route_chk #(.BUS_W(BUS_W), .FIELD_N(FIELD_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_be    (reg_be),
    .reg_rdata (reg_rdata),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_route (rsp_route)
);

// File: tb/cfg_route_top_bench.sv
module cfg_route_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_be = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_bus = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [1:0]  rsp_route;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_up = 0, m_below = 0, m_top = 0;

    always #10 clk = ~clk;

    cfg_route_top u_cfg_route_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_bus(req_bus), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_route(rsp_route)
    );

    function automatic logic [1:0] ref_route(logic [7:0] t, logic [7:0] up,
                                             logic [7:0] below, logic [7:0] top);
        if (t == below)                 return 2'd1; // R4
        if (t > below && t <= top)      return 2'd2; // R5
        if (t == up)                    return 2'd3; // R6
        return 2'd0;                                 // R7
    endfunction

    function automatic string tag_of(logic [1:0] r);
        case (r)
            2'd1: return "R4";
            2'd2: return "R5";
            2'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(logic [2:0] be, logic [23:0] d);
        if (be[0]) m_up    = d[7:0];
        if (be[1]) m_below = d[15:8];
        if (be[2]) m_top   = d[23:16];
    endtask

    task automatic reg_write(logic [2:0] be, logic [23:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(be, d);
        check("R2/R3 readback", reg_rdata, {m_top, m_below, m_up});
    endtask

    // One request; optional write on accept cycle and during the hold.
    task automatic do_req(logic [7:0] bus, int hold, logic wr_on_acc,
                          logic [2:0] be, logic [23:0] d);
        logic [1:0] exp;
        @(negedge clk);
        check("R8 ready idle", req_ready, 1'b1);
        exp = ref_route(bus, m_up, m_below, m_top);
        req_valid = 1'b1; req_bus = bus; rsp_ready = 1'b0;
        if (wr_on_acc) begin
            reg_wr = 1'b1; reg_be = be; reg_wdata = d;
        end
        @(negedge clk);
        req_valid = 1'b0; reg_wr = 1'b0;
        if (wr_on_acc) model_write(be, d);
        check("R8 rsp after accept", {req_ready, rsp_valid}, 2'b01);
        check(wr_on_acc ? "R10 route" : tag_of(exp), rsp_route, exp);
        for (int i = 0; i < hold; i++) begin
            if (i == 0 && !wr_on_acc && hold > 1) begin
                reg_wr = 1'b1; reg_be = be; reg_wdata = d;
                @(negedge clk);
                reg_wr = 1'b0;
                model_write(be, d);
                check("R10 readback", reg_rdata, {m_top, m_below, m_up});
            end else begin
                @(negedge clk);
            end
            check("R9 held valid", rsp_valid, 1'b1);
            check(hold > 1 ? "R10 held route" : "R9 held route", rsp_route, exp);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R9 released", {rsp_valid, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata", reg_rdata, 24'h0);
        check("R1 handshake", {rsp_valid, req_ready}, 2'b01);

        // all-zero registers: bus 0 hits bus-below first
        do_req(8'h00, 0, 1'b0, 3'b000, 24'h0);   // R4 priority
        do_req(8'h05, 0, 1'b0, 3'b000, 24'h0);   // R7 above top

        reg_write(3'b111, 24'h0A_05_02);         // up=2 below=5 top=10
        reg_write(3'b010, 24'hFF_06_FF);         // R2 only lane 1
        do_req(8'h06, 0, 1'b0, 3'b000, 24'h0);   // R4
        do_req(8'h07, 0, 1'b0, 3'b000, 24'h0);   // R5 low edge
        do_req(8'h0A, 0, 1'b0, 3'b000, 24'h0);   // R5 top edge
        do_req(8'h0B, 0, 1'b0, 3'b000, 24'h0);   // R7 above top
        do_req(8'h02, 0, 1'b0, 3'b000, 24'h0);   // R6
        do_req(8'h01, 0, 1'b0, 3'b000, 24'h0);   // R7 below up
        do_req(8'h04, 0, 1'b0, 3'b000, 24'h0);   // R7 between
        // collisions
        do_req(8'h06, 3, 1'b1, 3'b111, 24'h20_10_06); // R10 on accept
        do_req(8'h10, 4, 1'b0, 3'b011, 24'h00_30_10); // R10 during hold
        do_req(8'h10, 2, 1'b0, 3'b000, 24'h0);

        for (int it = 0; it < 400; it++) begin
            int sel;
            logic [7:0] bus;
            if ($urandom_range(0, 3) == 0)
                reg_write(3'($urandom_range(0, 7)), 24'($urandom));
            sel = $urandom_range(0, 7);
            case (sel)
                0: bus = m_up;
                1: bus = m_below;
                2: bus = m_top;
                3: bus = m_top + 8'd1;
                4: bus = m_below + 8'd1;
                5: bus = m_up - 8'd1;
                default: bus = 8'($urandom);
            endcase
            do_req(bus, $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                   3'($urandom_range(0, 7)), 24'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule